// File: doc/BRIEF.md
# Byte-Addressed GPIO Register Bank with Pin Interrupts

This block is a small GPIO controller on a single-cycle byte bus. The window starts with a read-only group of level bytes and continues with one control byte per pin. Each control byte holds three fields: a drive-enable flag, a drive value, and a readable input bit.

When drive is enabled, the input bit reflects what software wrote as the drive value. When drive is disabled, the input bit follows the sampled external pin. External pin inputs pass through a synchroniser and an edge detector, so the input bit moves only when the synchronised pin changes.

Two pins have a fixed interrupt polarity:
- The low-polarity pin raises its interrupt while its input bit is 0.
- The high-polarity pin raises its interrupt while its input bit is 1.

A one-cycle non-maskable request strobe sets the high-polarity pin's input bit for one cycle and clears it on the next, which gives exactly one interrupt pulse. If an external change arrives on a pin whose drive is enabled, the block sets a sticky conflict flag. That flag stays set until an external clear.

Top module: `gpio_regbank`

## Requirements
- R1: Offsets 0 to 7 read level byte k as `level_vals[8k+7:8k]`. Bus writes to these offsets change nothing.
- R2: Offsets 8 to 43 address pin byte (offset − 8). Bit 2 is drive enable, bit 1 is the input bit, and bit 0 is the drive value. Bits 7:3, 2 and 0 store the written data and read back unchanged.
- R3: A write with data bit 2 set loads bit 1 from data bit 0. A write with data bit 2 clear keeps the stored bit 1. Written bit 1 is always discarded.
- R4: A change on `pin_in[i]` passes through a two-flop synchroniser and an edge detector. The new value appears in bit 1 of pin byte i after the third rising edge.
- R5: If an external change is captured on a pin whose bit 2 is set, bit 1 still updates and `drive_err` becomes 1. `drive_err` stays 1 until `err_clr` is high at a rising edge.
- R6: `irq_out[1]` is the inverse of pin 1's bit 1, registered with one cycle of delay.
- R7: `irq_out[9]` equals pin 9's bit 1, registered with one cycle of delay.
- R8: A one-cycle `nmi_req` sets pin 9's bit 1 at the next edge and clears it at the following edge. This produces a single one-cycle pulse on `irq_out[9]`.
- R9: `irq_out[0]` and `irq_out[8:2]` are always 0.
- R10: After reset, every pin byte is 0x00 except pin 1, which is 0x02. `irq_out` is all zero and `drive_err` is 0.
- R11: Offsets 44 to 47 read 0x00, and writes to them change nothing.
- R12: `pin_oe[i]` and `pin_out[i]` present bit 2 and bit 0 of pin byte i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| level_vals | input | 64 | Contents of the eight level bytes |
| pin_in | input | 36 | Asynchronous external pin inputs |
| nmi_req | input | 1 | One-cycle non-maskable request strobe |
| err_clr | input | 1 | Clears the sticky conflict flag |
| pin_oe | output | 36 | Per-pin drive enable |
| pin_out | output | 36 | Per-pin drive value |
| irq_out | output | 10 | Interrupt outputs, indexed by pin |
| drive_err | output | 1 | Sticky flag for an input change on a driven pin |

## Verification
The bench builds the block with its default parameters: eight level bytes, thirty-six pins, ten interrupt outputs, low polarity on pin 1, high polarity on pin 9, and two synchroniser stages. These values make the last pin byte at offset 43 and the four padding offsets reachable. They also give the cycle counts that the synchroniser latency checks rely on. With these values the bench can observe interrupt activity and the non-maskable pulse on both polarity variants, while exercising the generated pin cells at both ends of the array.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int BIT_OUT = 0;
   localparam int BIT_IN  = 1;
   localparam int BIT_OE  = 2;
   typedef logic [7:0] gbyte_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int              W       = 36,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] chg_o
);
   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= async_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= stg[STAGES-1];

   assign sync_o = stg[STAGES-1];
   assign chg_o  = stg[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_pkg::*;
#(
   parameter gbyte_t RST_BYTE = 8'h00
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_en,
   input  gbyte_t wdata,
   input  logic   in_chg,
   input  logic   in_val,
   input  logic   force_hi,
   input  logic   force_lo,
   output gbyte_t reg_q,
   output logic   err_set
);
   gbyte_t nxt;

   always_comb begin
      nxt = reg_q;
      if (in_chg)   nxt[BIT_IN] = in_val;
      if (force_lo) nxt[BIT_IN] = 1'b0;
      if (force_hi) nxt[BIT_IN] = 1'b1;
      if (wr_en) begin
         nxt[7:BIT_OE] = wdata[7:BIT_OE];
         nxt[BIT_OUT]  = wdata[BIT_OUT];
         if (wdata[BIT_OE]) nxt[BIT_IN] = wdata[BIT_OUT];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) reg_q <= RST_BYTE;
      else        reg_q <= nxt;

   assign err_set = in_chg & reg_q[BIT_OE];
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
   parameter int NUM_IRQ  = 10,
   parameter int LOW_PIN  = 1,
   parameter int HIGH_PIN = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] in_bits,
   output logic [NUM_IRQ-1:0] irq_q
);
   generate
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
         if (i == LOW_PIN) begin : g_low
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) irq_q[i] <= 1'b0;
               else        irq_q[i] <= ~in_bits[i];
         end else if (i == HIGH_PIN) begin : g_high
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) irq_q[i] <= 1'b0;
               else        irq_q[i] <= in_bits[i];
         end else begin : g_none
            assign irq_q[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_pkg::*;
#(
   parameter int NUM_LEVEL   = 8,
   parameter int NUM_PINS    = 36,
   parameter int WIN_BYTES   = 48,
   parameter int NUM_IRQ     = 10,
   parameter int LOW_PIN     = 1,
   parameter int HIGH_PIN    = 9,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(WIN_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   input  logic [NUM_LEVEL*8-1:0] level_vals,
   input  logic [NUM_PINS-1:0]    pin_in,
   input  logic                   nmi_req,
   input  logic                   err_clr,
   output logic [NUM_PINS-1:0]    pin_oe,
   output logic [NUM_PINS-1:0]    pin_out,
   output logic [NUM_IRQ-1:0]     irq_out,
   output logic                   drive_err
);
   localparam int PIN_BASE = NUM_LEVEL;
   localparam int PIN_END  = NUM_LEVEL + NUM_PINS;
   localparam logic [NUM_PINS-1:0] IN_RST = NUM_PINS'(1) << LOW_PIN;

   generate
      if (PIN_END > WIN_BYTES)       begin : g_e0 $error("window too small"); end
      if (NUM_IRQ > NUM_PINS)        begin : g_e1 $error("too many irqs"); end
      if (LOW_PIN >= NUM_IRQ || HIGH_PIN >= NUM_IRQ || LOW_PIN == HIGH_PIN)
                                     begin : g_e2 $error("bad irq pins"); end
      if (SYNC_STAGES < 2)           begin : g_e3 $error("need two sync stages"); end
   endgenerate

   gbyte_t              pin_regs [NUM_PINS];
   logic [NUM_PINS-1:0] in_bits;
   logic [NUM_PINS-1:0] err_vec;
   logic [NUM_PINS-1:0] sync_v;
   logic [NUM_PINS-1:0] chg_v;
   logic                nmi_pend;
   logic                bus_we;

   assign bus_we = bus_sel & bus_wr;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(sync_v), .chg_o(chg_v));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) nmi_pend <= 1'b0;
      else        nmi_pend <= nmi_req;

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         localparam gbyte_t RB = (i == LOW_PIN) ? gbyte_t'(1 << BIT_IN) : gbyte_t'(0);
         logic wr_hit;
         assign wr_hit = bus_we && (bus_addr == ADDR_W'(PIN_BASE + i));
         gpio_pin_cell #(.RST_BYTE(RB)) u_cell (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wdata(bus_wdata),
            .in_chg(chg_v[i]), .in_val(sync_v[i]),
            .force_hi((i == HIGH_PIN) ? nmi_req  : 1'b0),
            .force_lo((i == HIGH_PIN) ? nmi_pend : 1'b0),
            .reg_q(pin_regs[i]), .err_set(err_vec[i]));
         assign in_bits[i] = pin_regs[i][BIT_IN];
         assign pin_oe[i]  = pin_regs[i][BIT_OE];
         assign pin_out[i] = pin_regs[i][BIT_OUT];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          drive_err <= 1'b0;
      else if (|err_vec)   drive_err <= 1'b1;
      else if (err_clr)    drive_err <= 1'b0;

   gpio_irq_map #(.NUM_IRQ(NUM_IRQ), .LOW_PIN(LOW_PIN), .HIGH_PIN(HIGH_PIN)) u_irq (
      .clk(clk), .rst_n(rst_n), .in_bits(in_bits[NUM_IRQ-1:0]), .irq_q(irq_out));

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_LEVEL; k++)
         if (bus_addr == ADDR_W'(k)) bus_rdata = level_vals[k*8 +: 8];
      for (int k = 0; k < NUM_PINS; k++)
         if (bus_addr == ADDR_W'(PIN_BASE + k)) bus_rdata = pin_regs[k];
   end
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int NUM_LEVEL = 8,
   parameter int NUM_PINS  = 36,
   parameter int NUM_IRQ   = 10,
   parameter int LOW_PIN   = 1,
   parameter int HIGH_PIN  = 9,
   parameter int ADDR_W    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [7:0]          bus_wdata,
   input logic [7:0]          bus_rdata,
   input logic                err_clr,
   input logic [NUM_PINS-1:0] in_bits,
   input logic [NUM_IRQ-1:0]  irq_out,
   input logic                drive_err
);
   localparam int PIN_END = NUM_LEVEL + NUM_PINS;
   localparam logic [NUM_IRQ-1:0] USED = (NUM_IRQ'(1) << LOW_PIN) | (NUM_IRQ'(1) << HIGH_PIN);

   logic              oe_wr;
   logic [ADDR_W-1:0] wr_pin_q;
   logic              wr_exp_q;
   assign oe_wr = bus_sel && bus_wr && (bus_addr >= ADDR_W'(NUM_LEVEL)) &&
                  (bus_addr < ADDR_W'(PIN_END)) && bus_wdata[2];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wr_pin_q <= '0;
         wr_exp_q <= 1'b0;
      end else begin
         wr_pin_q <= bus_addr - ADDR_W'(NUM_LEVEL);
         wr_exp_q <= bus_wdata[0];
      end

   AST_OE_WRITE_LOADS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      oe_wr |=> in_bits[wr_pin_q] == wr_exp_q); // R3
   AST_LOW_IRQ_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> irq_out[LOW_PIN] == !$past(in_bits[LOW_PIN])); // R6
   AST_HIGH_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> irq_out[HIGH_PIN] == $past(in_bits[HIGH_PIN])); // R7
   AST_UNUSED_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~USED) == '0); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      drive_err && !err_clr |=> drive_err); // R5
   AST_PAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= ADDR_W'(PIN_END)) |-> bus_rdata == 8'h00); // R11
endmodule

bind gpio_regbank gpio_regbank_chk #(
   .NUM_LEVEL(NUM_LEVEL), .NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ),
   .LOW_PIN(LOW_PIN), .HIGH_PIN(HIGH_PIN), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .err_clr(err_clr), .in_bits(in_bits), .irq_out(irq_out), .drive_err(drive_err)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [63:0] level_vals;
   logic [35:0] pin_in = 36'h2;
   logic        nmi_req = 1'b0, err_clr = 1'b0;
   logic [35:0] pin_oe, pin_out;
   logic [9:0]  irq_out;
   logic        drive_err;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_regbank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .level_vals(level_vals), .pin_in(pin_in), .nmi_req(nmi_req), .err_clr(err_clr),
      .pin_oe(pin_oe), .pin_out(pin_out), .irq_out(irq_out), .drive_err(drive_err));

   // {req(4), wr(1), addr(6), data(8), expected(8)}
   localparam logic [26:0] VEC [19] = '{
      {4'd1,  1'b0, 6'd0,  8'h00, 8'hA0},  // R1
      {4'd1,  1'b0, 6'd7,  8'h00, 8'hA7},  // R1
      {4'd1,  1'b1, 6'd3,  8'hFF, 8'h00},  // R1 write ignored
      {4'd1,  1'b0, 6'd3,  8'h00, 8'hA3},  // R1
      {4'd10, 1'b0, 6'd9,  8'h00, 8'h02},  // R10 pin 1 default
      {4'd10, 1'b0, 6'd8,  8'h00, 8'h00},  // R10
      {4'd3,  1'b1, 6'd8,  8'h05, 8'h00},  // R3
      {4'd3,  1'b0, 6'd8,  8'h00, 8'h07},  // R3
      {4'd3,  1'b1, 6'd8,  8'h01, 8'h00},  // R3
      {4'd3,  1'b0, 6'd8,  8'h00, 8'h03},  // R3 keep bit 1
      {4'd3,  1'b1, 6'd8,  8'h04, 8'h00},  // R3
      {4'd3,  1'b0, 6'd8,  8'h00, 8'h04},  // R3
      {4'd2,  1'b1, 6'd43, 8'hFA, 8'h00},  // R2
      {4'd2,  1'b0, 6'd43, 8'h00, 8'hF8},  // R2 last pin
      {4'd11, 1'b1, 6'd44, 8'hFF, 8'h00},  // R11
      {4'd11, 1'b0, 6'd44, 8'h00, 8'h00},  // R11
      {4'd11, 1'b0, 6'd47, 8'h00, 8'h00},  // R11
      {4'd2,  1'b1, 6'd20, 8'hFE, 8'h00},  // R2
      {4'd2,  1'b0, 6'd20, 8'h00, 8'hFC}   // R2
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_now(input string req, input logic [5:0] a, input logic [7:0] e);
      bus_addr = a;
      #0.5;
      chk(req, 32'(bus_rdata), 32'(e));
   endtask

   task automatic rd(input string req, input logic [5:0] a, input logic [7:0] e);
      @(negedge clk);
      rd_now(req, a, e);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 8; k++) level_vals[k*8 +: 8] = 8'hA0 + 8'(k);
      repeat (3) @(posedge clk);
      #1;
      chk("R10 irq", 32'(irq_out), 0);
      chk("R10 err", 32'(drive_err), 0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < 19; i++) begin
         logic [26:0] v;
         v = VEC[i];
         if (v[22]) wr(v[21:16], v[15:8]);
         else rd($sformatf("R%0d vec%0d", v[26:23], i), v[21:16], v[7:0]);
      end

      // R12 drive outputs
      wr(6'd10, 8'h01);
      #1;
      chk("R12 oe0", 32'(pin_oe[0]), 1);
      chk("R12 out0", 32'(pin_out[0]), 0);
      chk("R12 oe2", 32'(pin_oe[2]), 0);
      chk("R12 out2", 32'(pin_out[2]), 1);
      chk("R5 no err yet", 32'(drive_err), 0);

      // R4 / R6 low-polarity pin
      @(negedge clk) pin_in[1] = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rd_now("R4 pin1 bit", 6'd9, 8'h00);
      chk("R6 latency", 32'(irq_out[1]), 0);
      @(posedge clk); #1;
      chk("R6 asserted", 32'(irq_out[1]), 1);
      @(negedge clk) pin_in[1] = 1'b1;
      repeat (4) @(posedge clk); #1;
      chk("R6 released", 32'(irq_out[1]), 0);

      // R7 high-polarity pin
      @(negedge clk) pin_in[9] = 1'b1;
      repeat (4) @(posedge clk); #1;
      chk("R7 high", 32'(irq_out[9]), 1);
      @(negedge clk) pin_in[9] = 1'b0;
      repeat (4) @(posedge clk); #1;
      chk("R7 low", 32'(irq_out[9]), 0);

      // R9 / R4 unused pin
      @(negedge clk) pin_in[5] = 1'b1;
      repeat (3) @(posedge clk); #1;
      rd_now("R4 pin5", 6'd13, 8'h02);
      @(posedge clk); #1;
      chk("R9 quiet", 32'(irq_out), 0);
      chk("R5 undriven", 32'(drive_err), 0);

      // R5 conflict on driven pin 0 (byte 0x04)
      @(negedge clk) pin_in[0] = 1'b1;
      repeat (3) @(posedge clk); #1;
      rd_now("R5 bit updates", 6'd8, 8'h06);
      chk("R5 err set", 32'(drive_err), 1);
      repeat (2) @(posedge clk); #1;
      chk("R5 sticky", 32'(drive_err), 1);
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
      chk("R5 cleared", 32'(drive_err), 0);

      // R8 NMI pulse
      @(negedge clk) nmi_req = 1'b1;
      @(posedge clk); #1;
      rd_now("R8 bit high", 6'd17, 8'h02);
      chk("R8 irq not yet", 32'(irq_out[9]), 0);
      @(negedge clk) nmi_req = 1'b0;
      @(posedge clk); #1;
      chk("R8 pulse", 32'(irq_out[9]), 1);
      rd_now("R8 bit low", 6'd17, 8'h00);
      @(posedge clk); #1;
      chk("R8 pulse ends", 32'(irq_out[9]), 0);

      finish_run();
   end
endmodule